// File: doc/BRIEF.md
# Glitch-Free Programmable Master Clock Divider

This block turns a source clock into a slower internal master clock by dividing it by a programmable integer from 2 to 16. The source may be a fast external clock or a slow low-frequency clock; that choice is made upstream, and the divider behaves the same with either. Only rising source edges are used. The output comes straight from a flip-flop, so it is free of combinational glitches. As an example, a 44 MHz source divided by 3, 4 or 5 gives 14.67, 11 or 8.8 MHz.

Software writes a new divisor through a write strobe. The value is held aside and takes over only when the current output period ends. A running clock can therefore be slowed down or sped up without a shortened high or low phase. After reset the divisor is 16, the slowest setting, so start-up code runs safely whatever the source frequency. A read-back port shows the divisor of the period in progress, so software can confirm that a change has taken effect.

Top module: `mclk_divider`

## Requirements
- R1: A write with `div_wr` high and `div_wdata` (unsigned, 5 bits) in the range 2 to 16 is accepted, and that value becomes the divisor N of a later output period.
- R2: While `rst_n` is low on a rising edge, `clk_out` goes low and `div_active` becomes 16. On the first rising edge with `rst_n` high, `clk_out` rises and starts a period of 16 source cycles.
- R3: Each output period of divisor N lasts N source cycles. `clk_out` is high for floor(N/2) cycles, then low for the remaining N - floor(N/2) cycles.
- R4: An accepted write never alters the period in progress. That period completes at its old divisor, and the new divisor governs the period that starts at the next rise of `clk_out`.
- R5: A write of 0, 1 or 17 to 31 is ignored. `div_active` and the output periods remain as they were.
- R6: When several writes land within one period, the last accepted value takes effect at the next boundary. An out-of-range write in between does not cancel a pending valid one.
- R7: `div_active` shows the divisor of the period in progress. It changes on the same source edge on which `clk_out` rises to start a period at the new divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Source clock; only rising edges are used |
| rst_n | input | 1 | Synchronous active-low reset |
| div_wr | input | 1 | Write strobe for a new divisor, one cycle per write |
| div_wdata | input | 5 | Requested divisor, valid range 2 to 16 |
| clk_out | output | 1 | Divided master clock, driven from a register |
| div_active | output | 5 | Divisor of the output period in progress |

## Verification
If the phase counter lands on a wrong value, the next high or low phase of `clk_out` has the wrong length. This shows within one output period, at most 16 source cycles. If the pending or active divisor is corrupted, the first period after the next boundary has the wrong length, and `div_active` disagrees with the last accepted write at that same edge. The bench therefore measures every high and low phase against a queue of expected period shapes. It also compares `div_active` just after each write and just after each rise.

// File: rtl/mdiv_pkg.sv
// Package: shared limits and helpers for the master clock divider.
// Assumes divisor values are carried as unsigned integers wide enough for
// the largest divisor.
package mdiv_pkg;

    localparam int unsigned MDIV_MIN_DEF = 2;
    localparam int unsigned MDIV_MAX_DEF = 16;

    // Returns 1 when a requested divisor lies inside [lo, hi].
    function automatic logic div_in_range(input int unsigned val,
                                          input int unsigned lo,
                                          input int unsigned hi);
        return (val >= lo) && (val <= hi);
    endfunction

endpackage

// File: rtl/div_shadow.sv
// Module: div_shadow
// Holds the active divisor and a pending one written by software.
// Out-of-range writes are dropped. At a period boundary the active divisor
// takes the newest accepted value: a write on the boundary edge itself,
// else the pending value, else it stays unchanged.
// Assumes period_end is high for exactly the last source cycle of a period.
module div_shadow #(
    parameter int unsigned DMIN = 2,
    parameter int unsigned DMAX = 16,
    parameter int unsigned DW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_val,
    input  logic          period_end,
    output logic [DW-1:0] act_div,
    output logic [DW-1:0] nxt_div
);
    import mdiv_pkg::*;

    logic          wr_ok;
    logic          pend_v;
    logic [DW-1:0] pend_val;

    // Qualify the write strobe with the legal divisor range.
    always_comb begin
        wr_ok = wr_en && div_in_range(int'(wr_val), DMIN, DMAX);
    end

    // Pick the divisor that the next period would use.
    always_comb begin
        if (wr_ok)       nxt_div = wr_val;
        else if (pend_v) nxt_div = pend_val;
        else             nxt_div = act_div;
    end

    // Track the pending request and commit it only on a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_div  <= DW'(DMAX);
            pend_val <= DW'(DMAX);
            pend_v   <= 1'b0;
        end else begin
            if (wr_ok) pend_val <= wr_val;
            if (period_end) begin
                act_div <= nxt_div;
                pend_v  <= 1'b0;
            end else if (wr_ok) begin
                pend_v  <= 1'b1;
            end
        end
    end

    AST_ACTIVE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (act_div >= DW'(DMIN)) && (act_div <= DW'(DMAX))); // R1

    AST_RESET_SLOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> act_div == DW'(DMAX)); // R2

    AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(act_div)); // R4

    AST_BAD_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_ok) |=> $stable(pend_val)); // R5

    AST_LAST_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && !period_end) |=> (pend_v && pend_val == $past(wr_val))); // R6

endmodule

// File: rtl/div_phase_ctr.sv
// Module: div_phase_ctr
// Counts source cycles within an output period and drives the registered
// divided clock: high for the first floor(N/2) counts, low for the rest.
// Assumes cur_div only changes on the edge where period_end is high, and
// that nxt_div is the divisor chosen for the following period.
module div_phase_ctr #(
    parameter int unsigned DMAX = 16,
    parameter int unsigned DW   = 5,
    parameter int unsigned CW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] cur_div,
    input  logic [DW-1:0] nxt_div,
    output logic          period_end,
    output logic          clk_out
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    logic [DW-1:0] div_sel;
    logic [DW-1:0] half_sel;

    // Detect the last source cycle of the running period.
    always_comb begin
        period_end = (DW'(cnt) == (cur_div - DW'(1)));
    end

    // Next count and the divisor governing the next cycle.
    always_comb begin
        cnt_nxt  = period_end ? '0 : cnt + CW'(1);
        div_sel  = period_end ? nxt_div : cur_div;
        half_sel = div_sel >> 1;
    end

    // Advance the counter and register the output phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= CW'(DMAX - 1);
            clk_out <= 1'b0;
        end else begin
            cnt     <= cnt_nxt;
            clk_out <= (DW'(cnt_nxt) < half_sel);
        end
    end

    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out) |-> (cnt == '0)); // R3

    AST_FALL_AT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_out) |-> (DW'(cnt) == (cur_div >> 1))); // R3

endmodule

// File: rtl/mclk_divider.sv
// Module: mclk_divider (top)
// Programmable integer clock divider, 2..16, with a registered output.
// Divisor changes take effect only at output period boundaries.
// Assumes a single source clock domain; source selection is done upstream.
module mclk_divider #(
    parameter int unsigned DMIN = mdiv_pkg::MDIV_MIN_DEF,
    parameter int unsigned DMAX = mdiv_pkg::MDIV_MAX_DEF,
    parameter int unsigned DW   = 5
) (
    input  logic          clk_in,
    input  logic          rst_n,
    input  logic          div_wr,
    input  logic [DW-1:0] div_wdata,
    output logic          clk_out,
    output logic [DW-1:0] div_active
);
    localparam int unsigned CW = $clog2(DMAX);

    logic          period_end;
    logic [DW-1:0] nxt_div;

    div_shadow #(.DMIN(DMIN), .DMAX(DMAX), .DW(DW)) u_shadow (
        .clk        (clk_in),
        .rst_n      (rst_n),
        .wr_en      (div_wr),
        .wr_val     (div_wdata),
        .period_end (period_end),
        .act_div    (div_active),
        .nxt_div    (nxt_div)
    );

    div_phase_ctr #(.DMAX(DMAX), .DW(DW), .CW(CW)) u_phase (
        .clk        (clk_in),
        .rst_n      (rst_n),
        .cur_div    (div_active),
        .nxt_div    (nxt_div),
        .period_end (period_end),
        .clk_out    (clk_out)
    );

    AST_ACTIVE_MOVES_ON_RISE: assert property (@(posedge clk_in) disable iff (!rst_n)
        (div_active != $past(div_active)) |-> $rose(clk_out)); // R7

endmodule

// File: tb/sim_mclk_divider.sv
// Scoreboard bench: the driver queues the expected shape of each output
// period, and the monitor measures the phases at the falling source edge.
module sim_mclk_divider;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       div_wr;
    logic [4:0] div_wdata;
    logic       clk_out;
    logic [4:0] div_active;

    always #10 clk = ~clk; // 50 MHz

    mclk_divider u0 (
        .clk_in     (clk),
        .rst_n      (rst_n),
        .div_wr     (div_wr),
        .div_wdata  (div_wdata),
        .clk_out    (clk_out),
        .div_active (div_active)
    );

    typedef struct { int n; int hi; int lo; } per_t;
    per_t q[$];

    int   vec = 0;
    int   bad = 0;
    int   cur = 16;
    int   cyc = 0;
    int   hcnt = 0;
    int   lcnt = 0;
    bit   started = 0;
    logic prev_o = 1'b0;
    event rise_ev;

    always @(posedge clk) cyc++;

    function automatic per_t shape(int n);
        per_t p;
        p.n = n; p.hi = n / 2; p.lo = n - n / 2;
        return p;
    endfunction

    task automatic chk(string req, int act, int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: measure each completed period and compare it with the queue head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (clk_out && !prev_o) begin
                if (started) begin
                    vec++;
                    if (q.size() == 0) begin
                        bad++;
                        $display("FAIL R3 actual period %0d/%0d expected none queued", hcnt, lcnt);
                    end else begin
                        per_t e;
                        e = q.pop_front();
                        if (hcnt != e.hi || lcnt != e.lo) begin
                            bad++;
                            $display("FAIL R3/R4 N=%0d actual hi %0d lo %0d expected hi %0d lo %0d",
                                     e.n, hcnt, lcnt, e.hi, e.lo);
                        end
                    end
                end
                started = 1;
                hcnt = 1;
                lcnt = 0;
                ->rise_ev;
            end else if (clk_out) begin
                hcnt++;
            end else begin
                lcnt++;
            end
        end
        prev_o = clk_out;
    end

    // One write at a rise; the period in progress keeps the old divisor.
    task automatic step(int wv, bit ok);
        q.push_back(shape(cur));
        div_wdata = 5'(wv);
        div_wr = 1'b1;
        @(negedge clk);
        div_wr = 1'b0;
        chk(ok ? "R4 active held mid-period" : "R5 active after bad write", int'(div_active), cur);
        if (ok) cur = wv;
        @(rise_ev);
        chk("R7 active at rise", int'(div_active), cur);
    endtask

    // Two back-to-back writes within one period; last accepted one wins.
    task automatic dbl(int a, bit oka, int b, bit okb);
        q.push_back(shape(cur));
        div_wdata = 5'(a);
        div_wr = 1'b1;
        @(negedge clk);
        div_wdata = 5'(b);
        @(negedge clk);
        div_wr = 1'b0;
        chk("R6 active held during writes", int'(div_active), cur);
        if (okb) cur = b;
        else if (oka) cur = a;
        @(rise_ev);
        chk("R6 last valid write applied", int'(div_active), cur);
    endtask

    task automatic run(int k);
        repeat (k) begin
            q.push_back(shape(cur));
            @(rise_ev);
        end
        chk("R3 active steady", int'(div_active), cur);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int c0;
        rst_n = 1'b0;
        div_wr = 1'b0;
        div_wdata = 5'd0;
        repeat (3) @(negedge clk);
        chk("R2 clk_out in reset", int'(clk_out), 0);
        chk("R2 active in reset", int'(div_active), 16);
        rst_n = 1'b1;
        c0 = cyc;
        @(rise_ev);
        chk("R2 first rise one edge after release", cyc - c0, 1);
        chk("R2 active 16 after reset", int'(div_active), 16);
        run(1);                       // R2: a full 16-cycle period
        step(3, 1'b1);  run(2);       // R1 R4
        step(2, 1'b1);  run(3);       // R1 lower bound
        step(5, 1'b1);  run(2);
        step(0, 1'b0);  run(1);       // R5
        step(1, 1'b0);
        step(17, 1'b0);
        step(31, 1'b0); run(1);       // R5 still at 5
        step(16, 1'b1); run(1);       // R1 upper bound
        step(4, 1'b1);
        dbl(7, 1'b1, 0, 1'b0); run(1);  // R6 invalid does not cancel
        dbl(3, 1'b1, 9, 1'b1); run(1);  // R6 last valid wins
        step(2, 1'b1);
        step(16, 1'b1); run(1);       // R4 jump 2 to 16
        for (int n = 2; n <= 16; n++) begin
            step(n, 1'b1);
            run(1);                   // R3 every divisor
        end
        chk("R3 queue drained", q.size(), 0);
        summary();
        $finish;
    end

endmodule